// File: doc/BRIEF.md
# External Interrupt Line Controller

The controller watches a parameterised group of external interrupt pins (one to thirty-two lines). Each pin is brought into the clock domain through a two-flop synchronizer. A per-line sense configuration then decides whether the line fires on a low level, a high level, a rising edge or a falling edge. Fired lines are latched into a status register. Status bits are gated by a per-line mask and OR-reduced into a single interrupt request. A separate non-maskable output follows line 0 whenever the NMI enable bit is set.

Software reaches the block through a simple word bus: a write strobe, a byte address and 32-bit write data, with combinational read data selected by the address. Mask bits are changed only through separate set and clear locations, so that no read-modify-write is needed. Only implemented lines have storage. Software can therefore write all ones to the sense-select register and read it back to learn how many lines exist.

Top module: `xirq_ctrl`

## Requirements
- R1: While reset is held, every register location reads 0 and both `irq_o` and `nmi_o` are 0.
- R2: A write to 0x00 sets the mask bits where the data holds a 1. A write to 0x04 clears them. Zero data bits leave the mask unchanged. The mask reads back at 0x08.
- R3: With the sense-select bit (0x14) at 1, a line is level sensitive. A polarity bit (0x1C) of 1 fires on a high input and 0 fires on a low input. The status bit (read at 0x0C, bit i for line i) is set on every cycle the active level is present.
- R4: With the sense-select bit at 0, a line is edge sensitive. A direction bit (0x18) of 1 fires on a rising edge and 0 fires on a falling edge. The status bit stays set after the input returns.
- R5: Writing a 1 to a bit at 0x10 clears that status bit. If the line fires in the same cycle, the set wins, so an active level keeps the bit set.
- R6: `irq_o` is 1 exactly when some line has both its status bit and its mask bit set.
- R7: Bits at or above the line count read 0 in the mask, status, sense-select, direction and polarity registers. Writing all ones to 0x14 reads back as 2^N-1.
- R8: Bit 0 at 0x24 is the NMI enable. `nmi_o` is 1 when the enable is set and line 0's status bit is set, whatever line 0's mask bit holds.
- R9: An input change sets its status bit at the third rising clock edge after the change, and not at the second.
- R10: Writes to the read-only locations 0x08 and 0x0C change nothing. Reads of unused locations such as 0x20 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | N_LINES | Asynchronous external interrupt pins |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined masked interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request from line 0 |

## Verification
The bench sweeps all four sense types with both an active and an inactive input transition. A swapped polarity or a swapped edge direction therefore shows up as a missing or a spurious status bit. It checks that clearing an active level-mode line leaves the bit set, which catches a design where the clear wins. It also checks that the NMI fires while line 0 is masked, which catches a design that gates the NMI with the mask. Exact edge counting catches a missing or extra synchronizer stage. Writes of all ones expose storage on unimplemented lines, and writes to read-only locations expose stray decode.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFF_ENSET  = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_ENCLR  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_STCLR  = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_SENSE  = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_DIR    = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_POL    = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_NMI    = 6'h24;

    typedef struct packed {
        logic level_sel;  // 1: level sensing, 0: edge sensing
        logic rise_sel;   // edge mode: 1 rising, 0 falling
        logic high_sel;   // level mode: 1 high, 0 low
    } line_cfg_t;

    function automatic logic line_fires(line_cfg_t c, logic cur, logic prv);
        if (c.level_sel)
            return cur == c.high_sel;
        else if (c.rise_sel)
            return cur & ~prv;
        else
            return ~cur & prv;
    endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] pin_i,
    output logic [N_LINES-1:0] cur_o,
    output logic [N_LINES-1:0] prv_o
);
    logic [N_LINES-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            cur_o  <= '0;
            prv_o  <= '0;
        end else begin
            stage1 <= pin_i;
            cur_o  <= stage1;
            prv_o  <= cur_o;
        end
    end
endmodule

// File: rtl/xirq_sense.sv
module xirq_sense
    import xirq_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic [N_LINES-1:0] level_sel_i,
    input  logic [N_LINES-1:0] rise_sel_i,
    input  logic [N_LINES-1:0] high_sel_i,
    input  logic [N_LINES-1:0] cur_i,
    input  logic [N_LINES-1:0] prv_i,
    output logic [N_LINES-1:0] fire_o
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        line_cfg_t cfg;
        assign cfg = '{level_sel: level_sel_i[i], rise_sel: rise_sel_i[i], high_sel: high_sel_i[i]};
        assign fire_o[i] = line_fires(cfg, cur_i[i], prv_i[i]);
    end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] ext_pin,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o,
    output logic               nmi_o
);
    logic [N_LINES-1:0] cur, prv, fire;
    logic [N_LINES-1:0] line_mask, status, sense_r, dir_r, pol_r;
    logic               nmi_en;
    logic [N_LINES-1:0] wbits;
    logic               wr_set, wr_clr, wr_stclr;

    assign wbits    = bus_wdata[N_LINES-1:0];
    assign wr_set   = bus_wr && (bus_addr == OFF_ENSET);
    assign wr_clr   = bus_wr && (bus_addr == OFF_ENCLR);
    assign wr_stclr = bus_wr && (bus_addr == OFF_STCLR);

    xirq_sync #(.N_LINES(N_LINES)) u_sync (
        .clk(clk), .rst(rst), .pin_i(ext_pin), .cur_o(cur), .prv_o(prv)
    );

    xirq_sense #(.N_LINES(N_LINES)) u_sense (
        .level_sel_i(sense_r), .rise_sel_i(dir_r), .high_sel_i(pol_r),
        .cur_i(cur), .prv_i(prv), .fire_o(fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            line_mask <= '0;
            status    <= '0;
            sense_r   <= '0;
            dir_r     <= '0;
            pol_r     <= '0;
            nmi_en    <= 1'b0;
        end else begin
            if (wr_set)
                line_mask <= line_mask | wbits;
            else if (wr_clr)
                line_mask <= line_mask & ~wbits;
            status <= (status & ~(wr_stclr ? wbits : '0)) | fire;
            if (bus_wr && bus_addr == OFF_SENSE) sense_r <= wbits;
            if (bus_wr && bus_addr == OFF_DIR)   dir_r   <= wbits;
            if (bus_wr && bus_addr == OFF_POL)   pol_r   <= wbits;
            if (bus_wr && bus_addr == OFF_NMI)   nmi_en  <= bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_MASK:   bus_rdata = DATA_W'(line_mask);
            OFF_STATUS: bus_rdata = DATA_W'(status);
            OFF_SENSE:  bus_rdata = DATA_W'(sense_r);
            OFF_DIR:    bus_rdata = DATA_W'(dir_r);
            OFF_POL:    bus_rdata = DATA_W'(pol_r);
            OFF_NMI:    bus_rdata = {{(DATA_W-1){1'b0}}, nmi_en};
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_o = |(status & line_mask);
    assign nmi_o = nmi_en & status[0];

    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((line_mask & $past(wbits)) == $past(wbits))); // R2
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((line_mask & $past(wbits)) == '0)); // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|fire) |=> ((status & $past(fire)) == $past(fire))); // R5
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        wr_stclr |=> ((status & $past(wbits & ~fire)) == '0)); // R5
endmodule

// File: tb/sim_xirq_ctrl.sv
module sim_xirq_ctrl;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [N-1:0] ext_pin;
    logic        bus_wr;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_o, nmi_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xirq_ctrl #(.N_LINES(N)) u0 (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .nmi_o(nmi_o)
    );

    // {sense, dir, pol, pin_before, pin_after, expected status}
    localparam logic [5:0] VEC [8] = '{
        6'b101_01_1, 6'b101_00_0, 6'b100_10_1, 6'b100_11_0,
        6'b010_01_1, 6'b010_10_0, 6'b000_10_1, 6'b000_01_0
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(string req, logic [5:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; ext_pin = '1;
        idle(3);
        // R1: reset values
        rd("R1 mask",   6'h08, 0);
        rd("R1 status", 6'h0C, 0);
        rd("R1 sense",  6'h14, 0);
        rd("R1 dir",    6'h18, 0);
        rd("R1 pol",    6'h1C, 0);
        rd("R1 nmi",    6'h24, 0);
        chk("R1 irq_o", 32'(irq_o), 0);
        chk("R1 nmi_o", 32'(nmi_o), 0);
        @(negedge clk) rst = 1'b0;
        idle(4);

        // R3 R4: sense table on line 1
        for (int k = 0; k < 8; k++) begin
            @(negedge clk) ext_pin[1] = VEC[k][2];
            wr(6'h14, 32'(VEC[k][5]) << 1);
            wr(6'h18, 32'(VEC[k][4]) << 1);
            wr(6'h1C, 32'(VEC[k][3]) << 1);
            idle(4);
            wr(6'h10, 32'h2);
            @(negedge clk) ext_pin[1] = VEC[k][1];
            idle(4);
            rd(VEC[k][5] ? "R3 level sense" : "R4 edge sense", 6'h0C, 32'(VEC[k][0]) << 1);
            wr(6'h10, 32'hFF);
        end
        ext_pin = '1;
        wr(6'h14, 0); wr(6'h18, 0); wr(6'h1C, 0);
        idle(4);
        wr(6'h10, 32'hFF);

        // R9: latency on line 2 (falling edge)
        @(negedge clk) bus_addr = 6'h0C; ext_pin[2] = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R9 not at 2nd edge", bus_rdata & 32'h4, 0);
        @(posedge clk); #1;
        chk("R9 at 3rd edge", bus_rdata & 32'h4, 32'h4);
        @(negedge clk) ext_pin[2] = 1'b1;
        idle(5);
        rd("R4 status holds", 6'h0C, 32'h4);
        wr(6'h10, 32'h4);
        rd("R5 clear edge", 6'h0C, 0);

        // R2: mask set/clear
        wr(6'h00, 32'h0000_0005);
        rd("R2 set", 6'h08, 32'h05);
        wr(6'h00, 32'h0000_0010);
        rd("R2 set keeps", 6'h08, 32'h15);
        wr(6'h04, 32'h0000_0001);
        rd("R2 clear", 6'h08, 32'h14);
        wr(6'h04, 32'h0000_0000);
        rd("R2 zero no effect", 6'h08, 32'h14);
        wr(6'h04, 32'hFF);

        // R10: read-only and unused
        wr(6'h08, 32'hFFFF_FFFF);
        rd("R10 mask ro", 6'h08, 0);
        wr(6'h0C, 32'hFFFF_FFFF);
        rd("R10 status ro", 6'h0C, 0);
        rd("R10 unused", 6'h20, 0);

        // R7: implemented width
        wr(6'h14, 32'hFFFF_FFFF);
        rd("R7 sense width", 6'h14, 32'hFF);
        wr(6'h18, 32'hFFFF_FFFF);
        rd("R7 dir width", 6'h18, 32'hFF);
        wr(6'h00, 32'hFFFF_FFFF);
        rd("R7 mask width", 6'h08, 32'hFF);
        wr(6'h04, 32'hFFFF_FFFF);
        wr(6'h14, 0); wr(6'h18, 0);
        idle(4);
        wr(6'h10, 32'hFF);

        // R5: set wins on active level, line 3 level-high
        wr(6'h14, 32'h8); wr(6'h1C, 32'h8);
        @(negedge clk) ext_pin[3] = 1'b1;
        idle(4);
        wr(6'h10, 32'h8);
        rd("R5 set wins", 6'h0C, 32'h8);
        @(negedge clk) ext_pin[3] = 1'b0;
        idle(4);
        wr(6'h10, 32'h8);
        rd("R5 clear once inactive", 6'h0C, 0);

        // R6: irq on line 4 level-low
        wr(6'h14, 32'h10); wr(6'h1C, 0);
        @(negedge clk) ext_pin[4] = 1'b0;
        idle(4);
        chk("R6 masked no irq", 32'(irq_o), 0);
        wr(6'h00, 32'h10);
        #1 chk("R6 irq on", 32'(irq_o), 1);
        wr(6'h04, 32'h10);
        #1 chk("R6 irq off", 32'(irq_o), 0);
        @(negedge clk) ext_pin[4] = 1'b1;
        idle(4);
        wr(6'h10, 32'hFF);

        // R8: NMI from line 0, masked
        wr(6'h14, 32'h01); wr(6'h1C, 0);
        @(negedge clk) ext_pin[0] = 1'b0;
        idle(4);
        chk("R8 nmi disabled", 32'(nmi_o), 0);
        wr(6'h24, 32'h1);
        rd("R8 nmi reg", 6'h24, 1);
        chk("R8 nmi ignores mask", 32'(nmi_o), 1);
        chk("R8 irq stays masked", 32'(irq_o), 0);
        wr(6'h24, 32'h0);
        #1 chk("R8 nmi off", 32'(nmi_o), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule